// File: doc/BRIEF.md
# Adapter Reset and Bring-up Sequencer

This block owns three byte-wide control registers of a network adapter's glue logic: a reset-release register, an interrupt-control register and a FIFO-threshold register. It drives them through short, fixed programs. A start request runs the full bring-up. That program pulses the adapter core into reset, holds every reset line asserted for a timed interval, and then releases the lines one by one. It finishes by switching on the interrupt sources and programming the FIFO threshold. A stop request drops every reset line at once.

A third, lighter request releases only the core reset line and then waits out the same hold interval. Firmware uses it to bring the adapter far enough up to read its configuration store before the full start. While a program runs, the block reports itself busy. When the program ends, it gives a single-cycle completion pulse.

Top module: `arst_bringup_seq`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after it, all three registers read 0, and busy and done are low.
- R2: The reset register is active low per line, where 1 means released. Bit 0 releases the adapter core, bit 1 releases the host interface and bit 2 releases the FIFO. Bits 7..3 stay 0.
- R3: A start request runs the following writes, each as one write cycle plus one settle cycle. First it sets bit 0 and keeps the other bits. Next it clears bits 2..0 together. It then holds that state for HOLD_UNITS×PRESCALE cycles.
- R4: After the hold, a started sequence sets bit 0, then bit 1, then bit 2, one write (plus settle) each. The lines are therefore released in the order core, host interface, FIFO.
- R5: After the releases, the interrupt-control register is loaded with 0x03. Bit 0 is system interrupt enable and bit 1 is bus-error enable. No other value is ever written to it.
- R6: The FIFO-threshold register is loaded with 30 as the last step of a start. No other value is ever written to it.
- R7: An enable-only request sets bit 0 of the reset register, keeps bits 1 and 2, and then waits HOLD_UNITS×PRESCALE cycles.
- R8: A stop request writes 0 to the whole reset register and leaves the other two registers unchanged.
- R9: Busy rises in the cycle after an accepted request and stays high for 14+H cycles for a start, 2+H for an enable-only request and 2 for a stop, where H = HOLD_UNITS×PRESCALE. Requests that arrive while busy is high have no effect. When idle with no request, nothing changes.
- R10: Done is high for exactly one cycle: the first cycle in which busy is low again. A request presented in that cycle is accepted.
- R11: Requests that arrive together while idle are resolved with stop first, then start, then enable-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| open_req_i | input | 1 | Start (full bring-up) request |
| close_req_i | input | 1 | Stop request |
| enable_req_i | input | 1 | Enable-only request |
| reset_reg_o | output | 8 | Reset-release register value |
| irq_ctrl_o | output | 8 | Interrupt-control register value |
| fifo_thr_o | output | 8 | FIFO-threshold register value |
| busy_o | output | 1 | A program is running |
| done_o | output | 1 | One-cycle pulse when a program ends |

## Verification
The bench targets the following corner cases:
- **Release order.** It logs every value the reset register takes during a start. A design that swaps the release order, or skips the initial core pulse, shows a wrong log.
- **Hold length.** It measures busy cycles against the hold length, which exposes a timer that counts one cycle too many or too few.
- **Requests while busy.** It fires stop and enable-only requests in the middle of a hold. A design that fails to ignore them clears registers or ends early.
- **Enable-only on a running adapter.** It issues an enable-only request to an adapter that is already fully released, which catches a design that overwrites the host-interface and FIFO lines instead of keeping them.
- **Priority and back-to-back.** It presents simultaneous requests, and a request in the done cycle. These catch a wrong priority, and a sequencer that needs an extra idle cycle before it accepts new work.

// File: rtl/arst_seq_pkg.sv
package arst_seq_pkg;

    localparam int REG_W  = 8;
    localparam int STEP_W = 3;

    // reset-release lines, 1 = released
    localparam logic [REG_W-1:0] REL_CORE = 8'h01;
    localparam logic [REG_W-1:0] REL_HOST = 8'h02;
    localparam logic [REG_W-1:0] REL_FIFO = 8'h04;
    localparam logic [REG_W-1:0] REL_ALL  = REL_CORE | REL_HOST | REL_FIFO;

    localparam logic [REG_W-1:0] IRQ_SYS_EN  = 8'h01;
    localparam logic [REG_W-1:0] IRQ_BERR_EN = 8'h02;
    localparam logic [REG_W-1:0] FIFO_LEVEL  = 8'd30;

    localparam int NUM_TGT = 3;

    typedef enum logic [1:0] {OP_NONE, OP_OPEN, OP_ENABLE, OP_CLOSE} op_e;
    typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_SETTLE, ST_WAIT} state_e;
    typedef enum logic       {K_WRITE, K_WAIT} kind_e;
    typedef enum logic [1:0] {T_RST, T_IRQ, T_THR} tgt_e;
    typedef enum logic [1:0] {M_SET, M_CLR, M_LOAD} mode_e;

    typedef struct packed {
        kind_e            kind;
        tgt_e             tgt;
        mode_e            mode;
        logic [REG_W-1:0] val;
        logic             last;
    } step_t;

    function automatic op_e pick_op(logic op_open, logic op_close, logic op_en);
        if (op_close)      return OP_CLOSE;
        else if (op_open)  return OP_OPEN;
        else if (op_en)    return OP_ENABLE;
        else               return OP_NONE;
    endfunction

    function automatic step_t mk(kind_e k, tgt_e t, mode_e m, logic [REG_W-1:0] v, logic l);
        step_t s;
        s.kind = k;
        s.tgt  = t;
        s.mode = m;
        s.val  = v;
        s.last = l;
        return s;
    endfunction

    function automatic logic [REG_W-1:0] apply(logic [REG_W-1:0] cur, mode_e m, logic [REG_W-1:0] v);
        case (m)
            M_SET:   return cur | v;
            M_CLR:   return cur & ~v;
            default: return v;
        endcase
    endfunction

    // program store: one entry per step of each sequence
    function automatic step_t step_of(op_e op, logic [STEP_W-1:0] idx);
        step_t s;
        s = mk(K_WRITE, T_RST, M_SET, '0, 1'b1);
        case (op)
            OP_OPEN: begin
                case (idx)
                    3'd0: s = mk(K_WRITE, T_RST, M_SET,  REL_CORE,    1'b0);
                    3'd1: s = mk(K_WRITE, T_RST, M_CLR,  REL_ALL,     1'b0);
                    3'd2: s = mk(K_WAIT,  T_RST, M_SET,  '0,          1'b0);
                    3'd3: s = mk(K_WRITE, T_RST, M_SET,  REL_CORE,    1'b0);
                    3'd4: s = mk(K_WRITE, T_RST, M_SET,  REL_HOST,    1'b0);
                    3'd5: s = mk(K_WRITE, T_RST, M_SET,  REL_FIFO,    1'b0);
                    3'd6: s = mk(K_WRITE, T_IRQ, M_LOAD, IRQ_SYS_EN | IRQ_BERR_EN, 1'b0);
                    default: s = mk(K_WRITE, T_THR, M_LOAD, FIFO_LEVEL, 1'b1);
                endcase
            end
            OP_ENABLE: begin
                if (idx == 3'd0) s = mk(K_WRITE, T_RST, M_SET, REL_CORE, 1'b0);
                else             s = mk(K_WAIT,  T_RST, M_SET, '0,       1'b1);
            end
            OP_CLOSE: s = mk(K_WRITE, T_RST, M_LOAD, '0, 1'b1);
            default:  s = mk(K_WRITE, T_RST, M_SET, '0, 1'b1);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/arst_hold_timer.sv
module arst_hold_timer #(
    parameter int PRESCALE   = 4,
    parameter int HOLD_UNITS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic zero_o
);
    localparam int PRE_W  = $clog2(PRESCALE + 1);
    localparam int UNIT_W = $clog2(HOLD_UNITS + 1);
    localparam logic [PRE_W-1:0]  PRE_RELOAD  = PRE_W'(PRESCALE - 1);
    localparam logic [UNIT_W-1:0] UNIT_RELOAD = UNIT_W'(HOLD_UNITS - 1);

    logic [PRE_W-1:0]  pre_q;
    logic [UNIT_W-1:0] unit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            unit_q <= '0;
        end else if (load_i) begin
            pre_q  <= PRE_RELOAD;
            unit_q <= UNIT_RELOAD;
        end else if (pre_q != '0) begin
            pre_q <= pre_q - 1'b1;
        end else if (unit_q != '0) begin
            unit_q <= unit_q - 1'b1;
            pre_q  <= PRE_RELOAD;
        end
    end

    assign zero_o = (pre_q == '0) && (unit_q == '0);
endmodule

// File: rtl/arst_step_fetch.sv
module arst_step_fetch
    import arst_seq_pkg::*;
(
    input  op_e               op_i,
    input  logic [STEP_W-1:0] idx_i,
    input  op_e               req_i,
    output step_t             cur_o,
    output step_t             nxt_o,
    output step_t             first_o
);
    localparam logic [STEP_W-1:0] ONE = STEP_W'(1);
    logic [STEP_W-1:0] idx_nx;

    assign idx_nx  = idx_i + ONE;
    assign cur_o   = step_of(op_i, idx_i);
    assign nxt_o   = step_of(op_i, idx_nx);
    assign first_o = step_of(req_i, '0);
endmodule

// File: rtl/arst_reg_image.sv
module arst_reg_image
    import arst_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  step_t            step_i,
    output logic [REG_W-1:0] rst_reg_o,
    output logic [REG_W-1:0] irq_reg_o,
    output logic [REG_W-1:0] thr_reg_o
);
    logic [REG_W-1:0] regs_q [NUM_TGT];

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= '0;
            else if (wr_en_i && step_i.tgt == tgt_e'(g))
                regs_q[g] <= apply(regs_q[g], step_i.mode, step_i.val);
        end
    end

    assign rst_reg_o = regs_q[T_RST];
    assign irq_reg_o = regs_q[T_IRQ];
    assign thr_reg_o = regs_q[T_THR];
endmodule

// File: rtl/arst_bringup_seq.sv
module arst_bringup_seq
    import arst_seq_pkg::*;
#(
    parameter int PRESCALE   = 4,
    parameter int HOLD_UNITS = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       open_req_i,
    input  logic       close_req_i,
    input  logic       enable_req_i,
    output logic [7:0] reset_reg_o,
    output logic [7:0] irq_ctrl_o,
    output logic [7:0] fifo_thr_o,
    output logic       busy_o,
    output logic       done_o
);
    localparam logic [STEP_W-1:0] ONE = STEP_W'(1);

    state_e            state_q, state_n;
    op_e               op_q, op_n, req;
    logic [STEP_W-1:0] idx_q, idx_n;
    logic              done_q, done_n;
    logic              wr_en, advance, tmr_load, tmr_zero;
    step_t             cur, nxt, first;

    assign req = pick_op(open_req_i, close_req_i, enable_req_i);

    arst_step_fetch u_fetch (
        .op_i    (op_q),
        .idx_i   (idx_q),
        .req_i   (req),
        .cur_o   (cur),
        .nxt_o   (nxt),
        .first_o (first)
    );

    always_comb begin
        state_n = state_q;
        op_n    = op_q;
        idx_n   = idx_q;
        done_n  = 1'b0;
        wr_en   = 1'b0;
        advance = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req != OP_NONE) begin
                    op_n    = req;
                    idx_n   = '0;
                    state_n = (first.kind == K_WAIT) ? ST_WAIT : ST_WRITE;
                end
            end
            ST_WRITE: begin
                wr_en   = 1'b1;
                state_n = ST_SETTLE;
            end
            ST_SETTLE: advance = 1'b1;
            ST_WAIT:   advance = tmr_zero;
            default:   state_n = ST_IDLE;
        endcase
        if (advance) begin
            if (cur.last) begin
                state_n = ST_IDLE;
                op_n    = OP_NONE;
                done_n  = 1'b1;
            end else begin
                idx_n   = idx_q + ONE;
                state_n = (nxt.kind == K_WAIT) ? ST_WAIT : ST_WRITE;
            end
        end
    end

    assign tmr_load = (state_n == ST_WAIT) && (state_q != ST_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_NONE;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            op_q    <= op_n;
            idx_q   <= idx_n;
            done_q  <= done_n;
        end
    end

    arst_hold_timer #(
        .PRESCALE   (PRESCALE),
        .HOLD_UNITS (HOLD_UNITS)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (tmr_load),
        .zero_o (tmr_zero)
    );

    arst_reg_image u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .step_i    (cur),
        .rst_reg_o (reset_reg_o),
        .irq_reg_o (irq_ctrl_o),
        .thr_reg_o (fifo_thr_o)
    );

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;
endmodule

// File: rtl/arst_bringup_seq_chk.sv
module arst_bringup_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       open_req_i,
    input logic       close_req_i,
    input logic       enable_req_i,
    input logic [7:0] reset_reg_o,
    input logic [7:0] irq_ctrl_o,
    input logic [7:0] fifo_thr_o,
    input logic       busy_o,
    input logic       done_o
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (reset_reg_o == 8'h00 && irq_ctrl_o == 8'h00 && fifo_thr_o == 8'h00 && !busy_o && !done_o));

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        reset_reg_o[7:3] == 5'd0);

    p_host_after_core_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_reg_o[1]) |-> reset_reg_o[0]);

    p_fifo_last_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_reg_o[2]) |-> (reset_reg_o[1] && reset_reg_o[0]));

    p_irq_value_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(irq_ctrl_o) |-> irq_ctrl_o == 8'h03);

    p_thr_value_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(fifo_thr_o) |-> fifo_thr_o == 8'd30);

    p_writes_need_busy_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(reset_reg_o) |-> $past(busy_o));

    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !open_req_i && !close_req_i && !enable_req_i)
        |=> (!busy_o && $stable(reset_reg_o)));

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));
endmodule

bind arst_bringup_seq arst_bringup_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .open_req_i   (open_req_i),
    .close_req_i  (close_req_i),
    .enable_req_i (enable_req_i),
    .reset_reg_o  (reset_reg_o),
    .irq_ctrl_o   (irq_ctrl_o),
    .fifo_thr_o   (fifo_thr_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
);

// File: tb/arst_bringup_seq_test.sv
module arst_bringup_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int P = 2;
    localparam int U = 10;
    localparam int H = P * U;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic open_r = 1'b0, close_r = 1'b0, en_r = 1'b0;
    logic [7:0] rreg, ireg, treg;
    logic busy, done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    arst_bringup_seq #(.PRESCALE(P), .HOLD_UNITS(U)) uut (
        .clk (clk), .rst (rst),
        .open_req_i (open_r), .close_req_i (close_r), .enable_req_i (en_r),
        .reset_reg_o (rreg), .irq_ctrl_o (ireg), .fifo_thr_o (treg),
        .busy_o (busy), .done_o (done)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [25:0] q[$];
    logic [25:0] exp_v = '0;
    logic [7:0]  m_rst = 0, m_irq = 0, m_thr = 0;
    string       m_tag = "R1";
    bit          model_on = 0;

    function automatic void push_img(int copies);
        for (int i = 0; i < copies; i++) q.push_back({m_rst, m_irq, m_thr, 2'b10});
    endfunction

    function automatic void build(bit o, bit c, bit e);
        logic [25:0] t;
        if (c) begin
            m_tag = "R8";
            m_rst = 8'h00; push_img(2);
        end else if (o) begin
            m_tag = "R3";
            m_rst = m_rst | 8'h01; push_img(2);
            m_rst = m_rst & 8'hF8; push_img(2);
            push_img(H);
            m_rst = m_rst | 8'h01; push_img(2);
            m_rst = m_rst | 8'h02; push_img(2);
            m_rst = m_rst | 8'h04; push_img(2);
            m_irq = 8'h03;         push_img(2);
            m_thr = 8'd30;         push_img(2);
        end else begin
            m_tag = "R7";
            m_rst = m_rst | 8'h01; push_img(2);
            push_img(H);
        end
        t = q[q.size()-1];
        t[1:0] = 2'b01;
        q[q.size()-1] = t;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_rst = 0; m_irq = 0; m_thr = 0;
            exp_v = '0;
        end else if (q.size() > 0) begin
            exp_v = q.pop_front();
        end else if (open_r || close_r || en_r) begin
            exp_v = {m_rst, m_irq, m_thr, 2'b10};
            build(open_r, close_r, en_r);
        end else begin
            exp_v = {m_rst, m_irq, m_thr, 2'b00};
        end
    end

    always @(negedge clk) begin
        if (model_on && !rst) begin
            chk(m_tag, "reset_reg", rreg, exp_v[25:18]);
            chk("R5", "irq_ctrl", ireg, exp_v[17:10]);
            chk("R6", "fifo_thr", treg, exp_v[9:2]);
            chk("R9", "busy", busy, exp_v[1]);
            chk("R10", "done", done, exp_v[0]);
        end
    end

    // log of reset-register values for ordering checks
    logic [7:0] log_q[$];
    logic [7:0] last_r = 8'h00;
    bit         log_on = 0;
    always @(negedge clk) begin
        if (log_on && rreg != last_r) log_q.push_back(rreg);
        last_r = rreg;
    end

    // request launched at a negedge; returns at the done cycle
    task automatic run_op(bit o, bit c, bit e, output int busy_cycles);
        open_r = o; close_r = c; en_r = e;
        @(negedge clk);
        open_r = 0; close_r = 0; en_r = 0;
        busy_cycles = 0;
        while (busy && busy_cycles < 100000) begin
            busy_cycles++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int bc;
        repeat (3) @(negedge clk);
        chk("R1", "reset_reg in reset", rreg, 0);
        chk("R1", "busy in reset", busy, 0);
        rst = 0;
        model_on = 1;
        @(negedge clk);
        chk("R1", "regs after reset", {rreg, ireg, treg}, 0);
        chk("R1", "done after reset", done, 0);

        // enable-only from cleared state
        run_op(0, 0, 1, bc);
        chk("R7", "enable busy cycles", bc, 2 + H);
        chk("R10", "done at end of enable", done, 1);
        chk("R2", "core release is bit 0", rreg, 8'h01);

        // stop, then a logged start
        run_op(0, 1, 0, bc);
        chk("R8", "stop busy cycles", bc, 2);
        chk("R8", "stop clears reset reg", rreg, 0);
        log_q.delete(); log_on = 1;
        run_op(1, 0, 0, bc);
        log_on = 0;
        chk("R9", "start busy cycles", bc, 14 + H);
        chk("R3", "log length", log_q.size(), 5);
        if (log_q.size() == 5) begin
            chk("R3", "first write sets core", log_q[0], 8'h01);
            chk("R3", "all lines held", log_q[1], 8'h00);
            chk("R4", "core released first", log_q[2], 8'h01);
            chk("R4", "host released second", log_q[3], 8'h03);
            chk("R4", "fifo released last", log_q[4], 8'h07);
        end
        chk("R5", "irq control value", ireg, 8'h03);
        chk("R6", "fifo threshold value", treg, 8'd30);

        // requests during a running start are ignored
        open_r = 1;
        @(negedge clk);
        open_r = 0;
        bc = 0;
        while (busy && bc < 100000) begin
            if (bc == 5 || bc == 9) begin close_r = 1; en_r = 1; end
            else begin close_r = 0; en_r = 0; end
            bc++;
            @(negedge clk);
        end
        close_r = 0; en_r = 0;
        chk("R9", "ignored requests keep length", bc, 14 + H);
        chk("R9", "ignored stop keeps lines", rreg, 8'h07);

        // enable-only keeps host and fifo lines
        run_op(0, 0, 1, bc);
        chk("R7", "enable preserves lines", rreg, 8'h07);

        // stop keeps other registers; back-to-back in done cycle
        run_op(0, 1, 0, bc);
        chk("R8", "stop zero", rreg, 0);
        chk("R8", "stop keeps irq", ireg, 8'h03);
        chk("R8", "stop keeps thr", treg, 8'd30);
        chk("R10", "done before back-to-back", done, 1);
        run_op(0, 0, 1, bc);
        chk("R10", "request in done cycle accepted", bc, 2 + H);

        // simultaneous requests
        run_op(1, 0, 1, bc);
        chk("R11", "start beats enable-only", bc, 14 + H);
        run_op(1, 1, 1, bc);
        chk("R11", "stop beats all", bc, 2);
        chk("R11", "stop result", rreg, 0);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule